// File: doc/BRIEF.md
# Iterative Floating-Point Divider

This unit divides two floating-point operands that an earlier stage has already unpacked. Each operand arrives as a class code, a sign, a two's-complement exponent and a mantissa. For normal operands the mantissa holds a value in [1,2): its top bit is the integer one and its lowest bits serve as guard and round positions. A caller raises `start` for one cycle while the unit is idle. The operands are sampled on that edge.

Operand pairs that involve a zero, an infinity or a NaN are settled at once. The unit reports the result and the matching exception flag one cycle later. A pair of normal operands goes to a restoring shift-and-subtract engine that makes one quotient bit per cycle, from the top bit down. The first trial subtraction also picks the exponent adjustment, so the quotient comes out normalized with no shift afterwards. A sticky bit records whether the final remainder is nonzero. Rounding and packing happen downstream.

Top module: `fdiv_unit`

## Requirements
- R1: For normal operands with mantissas X and Y (W bits, bit W-1 the integer bit), `res_mant` equals floor(X·2^(W-1)/Y) when X ≥ Y and floor(X·2^W/Y) when X < Y. Bit W-1 of `res_mant` is always 1, and `res_cls` is normal (code 1).
- R2: For normal operands the result exponent is ea − eb when X ≥ Y and ea − eb − 1 when X < Y, computed modulo 2^EW.
- R3: For normal operands `res_sticky` is 1 exactly when the division in R1 leaves a nonzero remainder. It is 0 for every special result.
- R4: The result sign is the XOR of the operand signs for normal/normal, finite/infinity and finite/zero.
- R5: When either operand is a NaN (class 3 quiet, class 4 signalling), flag bit 0 is set. The result takes the class, sign, exponent and mantissa of the dividend when the dividend's class code is greater than the divisor's, and otherwise those of the divisor.
- R6: Infinity/infinity and zero/zero give a default NaN: class 3, sign 0, exponent 0, mantissa 0. Infinity/infinity sets flag bit 1, and zero/zero sets flag bit 2.
- R7: An infinite dividend with a finite or zero divisor, or a zero dividend with a normal or infinite divisor, returns the dividend unchanged and raises no flag.
- R8: A normal dividend over infinity gives zero (class 0, exponent 0, mantissa 0). A normal dividend over zero gives infinity (class 2, exponent 0, mantissa 0) and sets flag bit 3.
- R9: A special result shows `done` on the cycle after the start edge, with `busy` low throughout. A normal divide keeps `busy` high from the start edge for W cycles and shows `done` on the W-th cycle after the start edge. `done` is high for exactly one cycle. The class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN.
- R10: A `start` raised while `busy` is high is ignored. The divide in progress finishes with its own operands and its own latency.
- R11: While the unit is idle and `start` is low, all result outputs and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide; accepted only while idle |
| a_cls | input | 3 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EW | Dividend exponent, two's complement |
| a_mant | input | W | Dividend mantissa |
| b_cls | input | 3 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EW | Divisor exponent, two's complement |
| b_mant | input | W | Divisor mantissa |
| busy | output | 1 | A normal divide is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EW | Result exponent |
| res_mant | output | W | Result mantissa |
| res_sticky | output | 1 | Nonzero final remainder |
| exc_flags | output | 4 | [0] NaN operand, [1] inf/inf, [2] 0/0, [3] divide by zero |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a long divide. If the unit accepted it, the operands in flight would be replaced partway through the bit loop. The bench injects a start carrying infinity/infinity operands partway through several normal divides. It then checks that no early `done` appears, that `busy` stays high for the full W cycles, and that the quotient, exponent and flags match the first operand pair. The other hard case is the X < Y branch, where the 2X−Y first step must leave a quotient that is both normalized and exact. Vectors just below and just above Y, with all-ones and one-ulp mantissas, drive the unit into that branch and next to it.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NORM = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fclass_e;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_NONE = 2'd2
  } pick_e;

  localparam int NFLG    = 4;
  localparam int FLG_NAN = 0;
  localparam int FLG_IDI = 1;
  localparam int FLG_ZDZ = 2;
  localparam int FLG_DZ  = 3;

  function automatic logic is_nan(input logic [2:0] c);
    return (c == FC_QNAN) || (c == FC_SNAN);
  endfunction

endpackage

// File: rtl/fdiv_special.sv
module fdiv_special
  import fdiv_pkg::*;
(
  input  logic [2:0]      a_cls,
  input  logic [2:0]      b_cls,
  input  logic            a_sign,
  input  logic            b_sign,
  output logic            special_o,
  output logic [2:0]      cls_o,
  output logic            sign_o,
  output pick_e           pick_o,
  output logic [NFLG-1:0] flags_o
);

  always_comb begin
    special_o = 1'b1;
    cls_o     = a_cls;
    sign_o    = a_sign;
    pick_o    = PICK_A;
    flags_o   = '0;
    if (is_nan(a_cls) || is_nan(b_cls)) begin
      flags_o[FLG_NAN] = 1'b1;
      if (a_cls <= b_cls) begin
        cls_o  = b_cls;
        sign_o = b_sign;
        pick_o = PICK_B;
      end
    end else if (a_cls == FC_INF) begin
      if (b_cls == FC_INF) begin
        cls_o            = FC_QNAN;
        sign_o           = 1'b0;
        pick_o           = PICK_NONE;
        flags_o[FLG_IDI] = 1'b1;
      end
    end else if (a_cls == FC_ZERO) begin
      if (b_cls == FC_ZERO) begin
        cls_o            = FC_QNAN;
        sign_o           = 1'b0;
        pick_o           = PICK_NONE;
        flags_o[FLG_ZDZ] = 1'b1;
      end
    end else begin
      sign_o = a_sign ^ b_sign;
      pick_o = PICK_NONE;
      if (b_cls == FC_INF) begin
        cls_o = FC_ZERO;
      end else if (b_cls == FC_ZERO) begin
        cls_o           = FC_INF;
        flags_o[FLG_DZ] = 1'b1;
      end else begin
        special_o = 1'b0;
        cls_o     = FC_NORM;
      end
    end
  end

endmodule

// File: rtl/fdiv_mant_core.sv
module fdiv_mant_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         lt_o,
  output logic         last_o,
  output logic [W-1:0] quot_o,
  output logic         sticky_o
);

  localparam int RW = W + 1;

  logic [RW-1:0] rem_r, rem_n, y_ext, trial_1x, trial_2x, shifted, diff;
  logic [W-1:0]  quot_r, quot_n, bit_r, bit_n;

  always_comb begin
    y_ext    = {1'b0, y};
    trial_1x = {1'b0, x} - y_ext;
    trial_2x = {x, 1'b0} - y_ext;
    lt_o     = trial_1x[RW-1];
    shifted  = {rem_r[W-1:0], 1'b0};
    diff     = shifted - y_ext;
    rem_n    = rem_r;
    quot_n   = quot_r;
    bit_n    = bit_r;
    if (load) begin
      rem_n  = lt_o ? trial_2x : trial_1x;
      quot_n = {1'b1, {(W-1){1'b0}}};
      bit_n  = {2'b01, {(W-2){1'b0}}};
    end else if (step) begin
      if (!diff[RW-1]) begin
        rem_n  = diff;
        quot_n = quot_r | bit_r;
      end else begin
        rem_n  = shifted;
      end
      bit_n = bit_r >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r  <= '0;
      quot_r <= '0;
      bit_r  <= '0;
    end else if (load || step) begin
      rem_r  <= rem_n;
      quot_r <= quot_n;
      bit_r  <= bit_n;
    end
  end

  assign last_o   = bit_r[0];
  assign quot_o   = quot_r;
  assign sticky_o = |rem_r;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) || $past(step)) |-> (rem_r < y_ext)); // R3

  AST_BIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_r)); // R1

endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
  import fdiv_pkg::*;
#(
  parameter int W  = 64,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    a_cls,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [W-1:0]  a_mant,
  input  logic [2:0]    b_cls,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [W-1:0]  b_mant,
  output logic          busy,
  output logic          done,
  output logic [2:0]    res_cls,
  output logic          res_sign,
  output logic [EW-1:0] res_exp,
  output logic [W-1:0]  res_mant,
  output logic          res_sticky,
  output logic [3:0]    exc_flags
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ITER} state_e;

  state_e          st_r, st_n;
  logic            done_r, done_n;
  logic            op_en, core_load, core_step;
  logic            a_sign_r, b_sign_r;
  logic [EW-1:0]   a_exp_r, b_exp_r;
  logic [W-1:0]    a_mant_r, b_mant_r;
  logic [2:0]      cls_r, cls_n;
  logic            sign_r, sign_n;
  logic [EW-1:0]   exp_r, exp_n;
  logic [W-1:0]    smant_r, smant_n;
  logic            use_core_r, use_core_n;
  logic [NFLG-1:0] flags_r, flags_n;

  logic            sp_special, sp_sign;
  logic [2:0]      sp_cls;
  pick_e           sp_pick;
  logic [NFLG-1:0] sp_flags;
  logic            core_lt, core_last, core_sticky;
  logic [W-1:0]    core_quot;

  fdiv_special u_special (
    .a_cls     (a_cls),
    .b_cls     (b_cls),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .special_o (sp_special),
    .cls_o     (sp_cls),
    .sign_o    (sp_sign),
    .pick_o    (sp_pick),
    .flags_o   (sp_flags)
  );

  fdiv_mant_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (core_load),
    .step     (core_step),
    .x        (a_mant_r),
    .y        (b_mant_r),
    .lt_o     (core_lt),
    .last_o   (core_last),
    .quot_o   (core_quot),
    .sticky_o (core_sticky)
  );

  assign op_en = start && (st_r == ST_IDLE);

  always_comb begin
    st_n       = st_r;
    done_n     = 1'b0;
    core_load  = 1'b0;
    core_step  = 1'b0;
    cls_n      = cls_r;
    sign_n     = sign_r;
    exp_n      = exp_r;
    smant_n    = smant_r;
    use_core_n = use_core_r;
    flags_n    = flags_r;
    case (st_r)
      ST_IDLE: begin
        if (op_en) begin
          if (sp_special) begin
            done_n     = 1'b1;
            cls_n      = sp_cls;
            sign_n     = sp_sign;
            flags_n    = sp_flags;
            use_core_n = 1'b0;
            case (sp_pick)
              PICK_A:  begin exp_n = a_exp; smant_n = a_mant; end
              PICK_B:  begin exp_n = b_exp; smant_n = b_mant; end
              default: begin exp_n = '0;    smant_n = '0;     end
            endcase
          end else begin
            flags_n = '0;
            st_n    = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        core_load  = 1'b1;
        cls_n      = FC_NORM;
        sign_n     = a_sign_r ^ b_sign_r;
        exp_n      = a_exp_r - b_exp_r - {{(EW-1){1'b0}}, core_lt};
        use_core_n = 1'b1;
        st_n       = ST_ITER;
      end
      ST_ITER: begin
        core_step = 1'b1;
        if (core_last) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r       <= ST_IDLE;
      done_r     <= 1'b0;
      cls_r      <= '0;
      sign_r     <= 1'b0;
      exp_r      <= '0;
      smant_r    <= '0;
      use_core_r <= 1'b0;
      flags_r    <= '0;
      a_sign_r   <= 1'b0;
      b_sign_r   <= 1'b0;
      a_exp_r    <= '0;
      b_exp_r    <= '0;
      a_mant_r   <= '0;
      b_mant_r   <= '0;
    end else begin
      st_r       <= st_n;
      done_r     <= done_n;
      cls_r      <= cls_n;
      sign_r     <= sign_n;
      exp_r      <= exp_n;
      smant_r    <= smant_n;
      use_core_r <= use_core_n;
      flags_r    <= flags_n;
      if (op_en) begin
        a_sign_r <= a_sign;
        b_sign_r <= b_sign;
        a_exp_r  <= a_exp;
        b_exp_r  <= b_exp;
        a_mant_r <= a_mant;
        b_mant_r <= b_mant;
      end
    end
  end

  assign busy       = (st_r != ST_IDLE);
  assign done       = done_r;
  assign res_cls    = cls_r;
  assign res_sign   = sign_r;
  assign res_exp    = exp_r;
  assign res_mant   = use_core_r ? core_quot : smant_r;
  assign res_sticky = use_core_r & core_sticky;
  assign exc_flags  = flags_r;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sp_special) |=> (done && !busy)); // R9

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(a_mant_r) && $stable(b_mant_r) && $stable(a_exp_r))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_mant) && $stable(res_exp) && $stable(res_cls)
                           && $stable(exc_flags) && $stable(res_sticky))); // R11

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_flags)); // R6

endmodule

// File: tb/fdiv_unit_tb.sv
`timescale 1ns/1ps
module fdiv_unit_tb;

  localparam int W  = 64;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    a_cls, b_cls;
  logic          a_sign, b_sign;
  logic [EW-1:0] a_exp, b_exp;
  logic [W-1:0]  a_mant, b_mant;
  logic          busy, done;
  logic [2:0]    res_cls;
  logic          res_sign;
  logic [EW-1:0] res_exp;
  logic [W-1:0]  res_mant;
  logic          res_sticky;
  logic [3:0]    exc_flags;

  int n_checks = 0;
  int n_fails  = 0;

  fdiv_unit #(.W(W), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .busy(busy), .done(done), .res_cls(res_cls), .res_sign(res_sign),
    .res_exp(res_exp), .res_mant(res_mant), .res_sticky(res_sticky),
    .exc_flags(exc_flags)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  // expected result fields
  logic [2:0]    e_cls;
  logic          e_sign;
  logic [EW-1:0] e_exp;
  logic [W-1:0]  e_mant;
  logic          e_sticky;
  logic [3:0]    e_flags;
  int            e_lat;

  task automatic model(input logic [2:0] ac, input logic as, input logic [EW-1:0] ae,
                       input logic [W-1:0] am, input logic [2:0] bc, input logic bs,
                       input logic [EW-1:0] be, input logic [W-1:0] bm);
    logic [2*W:0] num, den, q, r;
    bit a_nan, b_nan;
    a_nan = (ac == 3) || (ac == 4);
    b_nan = (bc == 3) || (bc == 4);
    e_sticky = 1'b0; e_flags = 4'b0; e_lat = 0;
    if (a_nan || b_nan) begin
      e_flags = 4'b0001;
      if (ac > bc) begin e_cls = ac; e_sign = as; e_exp = ae; e_mant = am; end
      else         begin e_cls = bc; e_sign = bs; e_exp = be; e_mant = bm; end
    end else if ((ac == 2 && bc == 2) || (ac == 0 && bc == 0)) begin
      e_cls = 3; e_sign = 0; e_exp = 0; e_mant = 0;
      e_flags = (ac == 2) ? 4'b0010 : 4'b0100;
    end else if (ac == 2 || ac == 0) begin
      e_cls = ac; e_sign = as; e_exp = ae; e_mant = am;
    end else if (bc == 2) begin
      e_cls = 0; e_sign = as ^ bs; e_exp = 0; e_mant = 0;
    end else if (bc == 0) begin
      e_cls = 2; e_sign = as ^ bs; e_exp = 0; e_mant = 0; e_flags = 4'b1000;
    end else begin
      e_lat  = W;
      e_cls  = 1;
      e_sign = as ^ bs;
      den    = {{(W+1){1'b0}}, bm};
      num    = {{(W+1){1'b0}}, am};
      if (am >= bm) begin num = num << (W-1); e_exp = ae - be; end
      else          begin num = num << W;     e_exp = ae - be - 1'b1; end
      q = num / den;
      r = num % den;
      e_mant   = q[W-1:0];
      e_sticky = (r != 0);
    end
  endtask

  task automatic run_op(input string tag,
                        input logic [2:0] ac, input logic as, input logic [EW-1:0] ae,
                        input logic [W-1:0] am,
                        input logic [2:0] bc, input logic bs, input logic [EW-1:0] be,
                        input logic [W-1:0] bm, input int inject_at);
    model(ac, as, ae, am, bc, bs, be, bm);
    @(negedge clk);
    start = 1'b1;
    a_cls = ac; a_sign = as; a_exp = ae; a_mant = am;
    b_cls = bc; b_sign = bs; b_exp = be; b_mant = bm;
    @(negedge clk);
    start  = 1'b0;
    a_mant = ~am; b_mant = ~bm; a_exp = ~ae;
    for (int c = 0; c <= e_lat; c++) begin
      check(busy == (c < e_lat), "R9", {tag, " busy"}, W'(busy), W'(c < e_lat));
      check(done == (c == e_lat), (c < e_lat && c > inject_at && inject_at >= 0) ? "R10" : "R9",
            {tag, " done"}, W'(done), W'(c == e_lat));
      if (c == e_lat) begin
        check(res_cls == e_cls, (e_cls == 1) ? "R1" : "R5", {tag, " class"}, W'(res_cls), W'(e_cls));
        check(res_mant == e_mant, "R1", {tag, " mantissa"}, res_mant, e_mant);
        check(res_exp == e_exp, "R2", {tag, " exponent"}, W'(res_exp), W'(e_exp));
        check(res_sticky == e_sticky, "R3", {tag, " sticky"}, W'(res_sticky), W'(e_sticky));
        check(res_sign == e_sign, "R4", {tag, " sign"}, W'(res_sign), W'(e_sign));
        check(exc_flags == e_flags, "R6", {tag, " flags"}, W'(exc_flags), W'(e_flags));
      end
      if (c == inject_at && c < e_lat) begin
        start = 1'b1;
        a_cls = 3'd2; b_cls = 3'd2; a_mant = '1; b_mant = '1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b0, "R9", {tag, " done low after pulse"}, W'(done), '0);
    a_cls = 3'd4; b_cls = 3'd0; a_mant = '0;
    repeat (3) @(negedge clk);
    check(res_mant == e_mant && res_exp == e_exp && res_cls == e_cls && exc_flags == e_flags,
          "R11", {tag, " hold"}, res_mant, e_mant);
  endtask

  localparam logic [W-1:0] ONE  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONEH = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] ULP1 = {1'b1, {(W-2){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXM = '1;

  logic [W-1:0] lfsr;

  initial begin
    rst_n = 1'b0; start = 1'b0;
    a_cls = 0; b_cls = 0; a_sign = 0; b_sign = 0;
    a_exp = 0; b_exp = 0; a_mant = 0; b_mant = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R9", "reset handshake", W'({busy, done}), '0);
    check(res_mant == 0 && exc_flags == 0 && res_cls == 0, "R11", "reset outputs", res_mant, '0);

    // normal divides: R1 R2 R3 R4, with R10 injections
    run_op("R1 one/one",     3'd1, 0, 16'd3,    ONE,  3'd1, 0, 16'd3,    ONE,  -1);
    run_op("R2 1.5/1",       3'd1, 1, 16'd10,   ONEH, 3'd1, 0, -16'sd4,  ONE,  -1);
    run_op("R10 1/1.5",      3'd1, 0, 16'd0,    ONE,  3'd1, 1, 16'd0,    ONEH, 5);
    run_op("R3 max/ulp",     3'd1, 1, -16'sd20, MAXM, 3'd1, 1, 16'd7,    ULP1, 40);
    run_op("R1 one/max",     3'd1, 0, 16'h7fff, ONE,  3'd1, 0, 16'h8000, MAXM, -1);
    run_op("R3 ulp/one",     3'd1, 0, 16'd1,    ULP1, 3'd1, 1, 16'd1,    ONE,  0);
    lfsr = 64'h9e3779b97f4a7c15;
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] xa, xb;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      xa = lfsr | ONE;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      xb = lfsr | ONE;
      run_op("R1 mixed", 3'd1, xa[3], EW'(i * 5), xa, 3'd1, xb[5], EW'(-i), xb, i * 9);
    end

    // NaN cases: R5
    run_op("R5 qnan/norm", 3'd3, 1, 16'd9, ULP1, 3'd1, 0, 16'd2, ONE, -1);
    run_op("R5 norm/snan", 3'd1, 0, 16'd9, ONE,  3'd4, 1, 16'd4, ULP1, -1);
    run_op("R5 snan/qnan", 3'd4, 0, 16'd5, ONEH, 3'd3, 1, 16'd6, ULP1, -1);
    run_op("R5 qnan/qnan", 3'd3, 0, 16'd5, ONEH, 3'd3, 1, 16'd6, ULP1, -1);
    // invalid forms: R6
    run_op("R6 inf/inf",   3'd2, 1, 16'd0, 0, 3'd2, 0, 16'd0, 0, -1);
    run_op("R6 zero/zero", 3'd0, 1, 16'd0, 0, 3'd0, 1, 16'd0, 0, -1);
    // dividend returned: R7
    run_op("R7 inf/norm",  3'd2, 1, 16'd3, 0, 3'd1, 0, 16'd1, ONE, -1);
    run_op("R7 inf/zero",  3'd2, 0, 16'd3, 0, 3'd0, 1, 16'd1, 0,   -1);
    run_op("R7 zero/norm", 3'd0, 1, 16'd2, 0, 3'd1, 0, 16'd1, ONE, -1);
    run_op("R7 zero/inf",  3'd0, 0, 16'd2, 0, 3'd2, 1, 16'd1, 0,   -1);
    // finite over special: R8 with sign rule R4
    run_op("R8 norm/inf",  3'd1, 1, 16'd4, ONEH, 3'd2, 0, 16'd0, 0, -1);
    run_op("R8 norm/zero", 3'd1, 1, 16'd4, ONEH, 3'd0, 1, 16'd0, 0, -1);

    summary();
    $finish;
  end

endmodule